// File: doc/BRIEF.md
# Video Transfer Bus Handshake Controller

This controller moves processed video words from the accumulators onto a shared data bus that feeds an output memory. An active-low halt request starts a transfer. While the transfer runs, the processor side is held off. The controller then emits one word per slot, and each slot lasts four base clock cycles. A slot carries a word only if the shared bus is free and no auxiliary input source is asking for the bus. An auxiliary source claims priority by pulling its active-low disable low. Transfer resumes at the first slot boundary after that line returns high.

Each word raises a bus-drive enable for four cycles. It also produces one active-low write-cycle strobe, which is gated from the base clock, a half-rate phase and a quarter-rate phase. The quarter-rate phase is the master timing, so words leave at one-fourth of the base rate. A range-cell address counts the words. After the last cell has been sent, the controller reports completion and waits for the halt request to be released. An initialization reset from the processor returns the controller to idle from any state.

Top module: `vid_xfer_ctl`

## Requirements
- R1: After `rst_n` low, or a cycle with `init_n` low, the controller is idle: `cpu_inhibit`=0, `vid_drive`=0, `wc_n`=1, `xfer_done`=0, `cell_addr`=0.
- R2: `halt_n` low sampled in idle sets `cpu_inhibit`=1 from the next cycle. The first slot boundary is the clock edge that follows. `vid_drive` is 0 whenever `cpu_inhibit` is 0.
- R3: A word starts at a slot boundary only if `bus_avail` is 1 at that edge. Otherwise the slot stays empty, with `vid_drive`=0.
- R4: `aux_n` low at a slot boundary leaves that slot empty. A word already in progress always runs its full 4 cycles, whatever `aux_n` or `bus_avail` do meanwhile.
- R5: When `aux_n` is high again (and `bus_avail` is 1) at a later slot boundary, words resume from the address where they stopped.
- R6: `wc_n` is low for exactly one cycle per word, in the third of its four cycles. It is the AND of the active word, the quarter-rate phase high and the half-rate phase low.
- R7: `cell_addr` holds during a word and increments by one at the edge that ends it. When word `NWORDS-1` ends, `xfer_done`=1 and `cpu_inhibit`=0, and no further word is driven.
- R8: While `xfer_done`=1, `halt_n` high returns the controller to idle with `cell_addr`=0.
- R9: `init_n` low in the middle of a word aborts the transfer, and the controller is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base (5 MHz-equivalent) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Synchronous active-low initialization reset from the processor |
| halt_n | input | 1 | Active-low transfer request |
| aux_n | input | 1 | Active-low disable from the auxiliary input source |
| bus_avail | input | 1 | High when the data bus may carry video |
| cpu_inhibit | output | 1 | High while the transfer holds off the processor |
| vid_drive | output | 1 | High for each cycle a video word is on the bus |
| wc_n | output | 1 | Active-low write-cycle strobe to the output memory |
| cell_addr | output | $clog2(NWORDS) | Range-cell address of the current word |
| xfer_done | output | 1 | High after the last cell has been transferred |

## Verification
Complete transfers are run with every combination of free, bus-busy, auxiliary-busy and both-busy over the first three slots. This shows whether each of the two gating inputs alone leaves a slot empty, and whether the address resumes correctly after any run of empty slots. Each combination is run twice: once with steady inputs, and once with both gating inputs pulled low in the middle of every word. The second run separates sampling at the slot boundary from level-sensitive gating that would cut a word short. Separate runs abort a transfer with the initialization reset and release the halt after completion.

// File: rtl/vid_xfer_ctl.sv
module vid_xfer_ctl #(
  parameter int NWORDS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      init_n,
  input  logic                      halt_n,
  input  logic                      aux_n,
  input  logic                      bus_avail,
  output logic                      cpu_inhibit,
  output logic                      vid_drive,
  output logic                      wc_n,
  output logic [$clog2(NWORDS)-1:0] cell_addr,
  output logic                      xfer_done
);
  localparam int AW = $clog2(NWORDS);
  localparam logic [AW-1:0] LAST = AW'(NWORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t           st;
  logic [1:0]    div;
  logic          word_act;
  logic [AW-1:0] addr;

  // phase taps: clk is the base rate, div[0] the half rate, div[1] the quarter rate
  logic ph_half, ph_quarter, slot_end, last_word;
  assign ph_half    = div[0];
  assign ph_quarter = div[1];
  assign slot_end   = ph_quarter & ph_half;
  assign last_word  = word_act & (addr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= 2'd0;
      word_act <= 1'b0;
      addr     <= '0;
    end else if (!init_n) begin
      st       <= S_IDLE;
      div      <= 2'd0;
      word_act <= 1'b0;
      addr     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!halt_n) begin
            st  <= S_RUN;
            div <= 2'd3;
          end
        end
        S_RUN: begin
          div <= div + 2'd1;
          if (slot_end) begin
            if (last_word) begin
              st       <= S_DONE;
              word_act <= 1'b0;
            end else begin
              if (word_act) addr <= addr + 1'b1;
              word_act <= bus_avail & aux_n;
            end
          end
        end
        S_DONE: begin
          div <= 2'd0;
          if (halt_n) begin
            st   <= S_IDLE;
            addr <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_inhibit = (st == S_RUN);
  assign xfer_done   = (st == S_DONE);
  assign vid_drive   = word_act;
  assign wc_n        = ~(word_act & ph_quarter & ~ph_half);
  assign cell_addr   = addr;
endmodule

// File: rtl/vid_xfer_ctl_chk.sv
module vid_xfer_ctl_chk #(
  parameter int NWORDS = 256
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      init_n,
  input logic                      aux_n,
  input logic                      bus_avail,
  input logic                      cpu_inhibit,
  input logic                      vid_drive,
  input logic                      wc_n,
  input logic [$clog2(NWORDS)-1:0] cell_addr,
  input logic                      xfer_done
);
  logic [1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 2'd0;
    else        run_len <= vid_drive ? run_len + 2'd1 : 2'd0;
  end

  AST_STROBE_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
    !wc_n |-> (vid_drive && run_len == 2'd2));  // R6
  AST_WHOLE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vid_drive) && $past(init_n)) |-> run_len == 2'd0);  // R4
  AST_START_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_drive) |-> $past(bus_avail));  // R3
  AST_START_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_drive) |-> $past(aux_n));  // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_drive && $past(vid_drive) && run_len != 2'd0) |-> $stable(cell_addr));  // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!vid_drive && wc_n && !cpu_inhibit));  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_inhibit |-> !vid_drive);  // R2
endmodule

bind vid_xfer_ctl vid_xfer_ctl_chk #(.NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_n(init_n), .aux_n(aux_n),
  .bus_avail(bus_avail), .cpu_inhibit(cpu_inhibit), .vid_drive(vid_drive),
  .wc_n(wc_n), .cell_addr(cell_addr), .xfer_done(xfer_done)
);

// File: tb/test_vid_xfer_ctl.sv
`timescale 1ns/1ps
module test_vid_xfer_ctl;
  localparam int N  = 4;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0, init_n = 1'b1, halt_n = 1'b1, aux_n = 1'b1, bus_avail = 1'b1;
  logic cpu_inhibit, vid_drive, wc_n, xfer_done;
  logic [AW-1:0] cell_addr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vid_xfer_ctl #(.NWORDS(N)) i_vid_xfer_ctl (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .halt_n(halt_n), .aux_n(aux_n),
    .bus_avail(bus_avail), .cpu_inhibit(cpu_inhibit), .vid_drive(vid_drive),
    .wc_n(wc_n), .cell_addr(cell_addr), .xfer_done(xfer_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check({req, " inhibit"}, cpu_inhibit, 0);
    check({req, " drive"}, vid_drive, 0);
    check({req, " strobe"}, wc_n, 1);
    check({req, " done"}, xfer_done, 0);
    check({req, " addr"}, cell_addr, 0);
  endtask

  // slot kind: bit0 = bus busy, bit1 = auxiliary busy
  task automatic apply_slot(input int kind);
    bus_avail = !kind[0];
    aux_n     = !kind[1];
  endtask

  task automatic run_xfer(input int pat, input bit glitch);
    int sent = 0;
    int slot = 0;
    @(negedge clk);
    halt_n = 1'b0;
    apply_slot(pat & 3);
    @(posedge clk);
    @(negedge clk);
    check("R2 inhibit on", cpu_inhibit, 1);
    check("R2 no word before boundary", vid_drive, 0);
    while (sent < N) begin
      int kind;
      bit word;
      kind = (slot < 3) ? ((pat >> (2 * slot)) & 3) : 0;
      word = (kind == 0);
      @(posedge clk);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (word) begin
          check("R4 word full length", vid_drive, 1);
          check("R6 strobe phase", wc_n, (c == 2) ? 0 : 1);
        end else begin
          check(kind[0] ? "R3 bus busy slot empty" : "R4 aux busy slot empty", vid_drive, 0);
          check("R6 no strobe in empty slot", wc_n, 1);
        end
        check("R5 addr resumes", cell_addr, sent);
        check("R2 inhibit held", cpu_inhibit, 1);
        if (glitch && word && c == 1) begin
          bus_avail = 1'b0;
          aux_n = 1'b0;
        end
        if (c == 3) begin
          int nk;
          nk = (slot + 1 < 3) ? ((pat >> (2 * (slot + 1))) & 3) : 0;
          apply_slot(nk);
        end
      end
      if (word) sent++;
      slot++;
    end
    @(posedge clk);
    @(negedge clk);
    check("R7 done", xfer_done, 1);
    check("R7 inhibit off", cpu_inhibit, 0);
    check("R7 no drive", vid_drive, 0);
    check("R7 last addr", cell_addr, N - 1);
    repeat (3) @(negedge clk);
    check("R7 done held", xfer_done, 1);
    check("R7 no word after last", vid_drive, 0);
    halt_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_idle("R8");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 out of reset");

    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 64; p++)
        run_xfer(p, g[0]);

    // R9: abort in the middle of the second word
    @(negedge clk);
    halt_n = 1'b0;
    apply_slot(0);
    repeat (6) @(negedge clk);
    check("R9 word in progress", vid_drive, 1);
    init_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    halt_n = 1'b1;
    check_idle("R9 abort");
    check_idle("R1 init");
    init_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 stays idle");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule